// File: doc/BRIEF.md
# System-bus to byte-wide register bridge

This block is a Wishbone slave on a 32-bit system bus. It turns every bus access into one access on an internal register bus whose data word is 8 bits. Each 8-bit register word occupies its own aligned 32-bit slot in the system address map, so the register word index is simply the bus word address. The block also holds a small bank of peripheral registers of arbitrary width. Each register is split into 8-bit words placed in consecutive slots, so multi-word reads and writes can be exercised.

A byte address is split into three fields. The two lowest bits are ignored. The next `IDX_W` bits select a register word inside the bank. All remaining upper bits must equal `BANK_ID` for the bank to respond.

There is no stall and no wait state. A master raises `cyc` and `stb` and holds them until `ack`. That `ack` always arrives one cycle later and lasts a single cycle, so the only back-pressure the master sees is this fixed one-cycle wait.

The bank has two kinds of register:
- Write-only control registers drive output pins.
- Read-only status registers sample input pins.

Wide control registers are written most-significant word first. The value reaches the output pins only when the least significant word is written.

Top module: `wb_csr_bridge`

## Requirements
- R1: When `wb_cyc` and `wb_stb` are high and `wb_ack` is low at a clock edge, `wb_ack` is high in the following cycle. `wb_ack` is never high in two consecutive cycles.
- R2: While `wb_ack` is high, `wb_dat_r[31:8]` is zero. `wb_dat_r` is all zero whenever `wb_ack` is low and for every write acknowledge.
- R3: A register of N bits spans ceil(N/8) words, most significant word at its lowest index. For example, the 9-bit status register places its bit 8 in bit 0 of word index 4 and its bits 7:0 in word index 5.
- R4: High bits beyond a register's width read as zero and are ignored on write. For example, only bit 0 of a write to the 1-bit mode word (index 3) is kept, and only bits 3:0 of a write to word index 0 of the 20-bit control register are kept.
- R5: Writes to the upper words of the 20-bit control register (indices 0 and 1) go to a holding store only. `ctrl_q` changes, all 20 bits at once, only when word index 2 is written.
- R6: A write takes effect only when `wb_sel[0]` is high. Otherwise it is acknowledged and discarded.
- R7: Writes to read-only words and to unmapped indices are acknowledged and change no register.
- R8: Reads of write-only words and of unmapped indices return zero.
- R9: When address bits above the index field differ from `BANK_ID`, reads return zero and writes are discarded, but the access is still acknowledged.
- R10: Address bits 1:0 have no effect on decoding.
- R11: During reset, `wb_ack`, `ctrl_q` and `mode_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Byte address |
| wb_dat_w | input | 32 | Write data; only bits 7:0 are used |
| wb_sel | input | 4 | Byte lane selects; only bit 0 is used |
| wb_dat_r | output | 32 | Read data |
| wb_ack | output | 1 | Acknowledge, one cycle per request |
| stat_i | input | STAT_W | Status value sampled by reads |
| ctrl_q | output | CTRL_W | Committed control register |
| mode_q | output | MODE_W | Committed mode register |

## Verification
The bench builds the block with `IDX_W` = 4 and `BANK_ID` = 5, which gives a 26-bit bank field, and keeps the defaults of a 20-bit control register, a 1-bit mode register and a 9-bit status register. This lets a three-word register with a partly used top word, a single-word register with seven dead bits, and a two-word read-only register sit together in one sixteen-word bank. Unmapped indices (6 to 15) and a neighbouring bank are then easy to reach. Back-to-back requests, where the strobe is never dropped, are also driven to exercise the single-acknowledge rule.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

  localparam int CSR_DW = 8;

  typedef logic [CSR_DW-1:0] csr_word_t;

  function automatic int csr_words(input int bits);
    return (bits + CSR_DW - 1) / CSR_DW;
  endfunction

endpackage

// File: rtl/wb_csr_front.sv
module wb_csr_front
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int BANK_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADDR_W-1:0] adr,
  input  logic [7:0]       wdat,
  input  logic             sel0,
  output logic             req,
  output logic             req_we,
  output logic             req_sel0,
  output logic             req_hit,
  output logic [IDX_W-1:0] req_idx,
  output csr_word_t        req_wdat,
  output logic             ack
);

  localparam int BANK_LO = 2 + IDX_W;
  localparam int BANK_W  = ADDR_W - BANK_LO;

  logic [BANK_W-1:0] bank_f;

  assign bank_f   = adr[ADDR_W-1:BANK_LO];
  assign req      = cyc && stb && !ack;
  assign req_we   = we;
  assign req_sel0 = sel0;
  assign req_idx  = adr[BANK_LO-1:2];
  assign req_wdat = wdat;
  assign req_hit  = (bank_f == BANK_W'(BANK_ID));

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= req;
  end

  // R1
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
  // R1
  ack_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

endmodule

// File: rtl/csr_wo_reg.sv
module csr_wo_reg
  import csr_bridge_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BASE  = 0,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  csr_word_t        wdat,
  output logic [WIDTH-1:0] q
);

  localparam int NW  = csr_words(WIDTH);
  localparam int PW  = NW * CSR_DW;
  localparam int LSW = BASE + NW - 1;

  logic [PW-1:0] stage;
  logic [PW-1:0] merged;
  logic          commit;
  logic          unused_pad;

  assign commit = wr && (idx == IDX_W'(LSW));

  always_comb begin
    merged      = stage;
    merged[7:0] = wdat;
  end
  assign unused_pad = ^merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
      q     <= '0;
    end else begin
      for (int k = 0; k < NW - 1; k++) begin
        if (wr && idx == IDX_W'(BASE + k))
          stage[(NW-1-k)*CSR_DW +: CSR_DW] <= wdat;
      end
      if (commit) q <= merged[WIDTH-1:0];
    end
  end

  // R5
  commit_only_lsw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(wr && idx == IDX_W'(LSW)));

endmodule

// File: rtl/csr_ro_reg.sv
module csr_ro_reg
  import csr_bridge_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BASE  = 0,
  parameter int IDX_W = 4
) (
  input  logic [WIDTH-1:0] val,
  input  logic [IDX_W-1:0] idx,
  output logic             hit,
  output csr_word_t        word
);

  localparam int NW = csr_words(WIDTH);
  localparam int PW = NW * CSR_DW;

  logic [PW-1:0] padded;

  assign padded = PW'(val);

  always_comb begin
    hit  = 1'b0;
    word = '0;
    for (int k = 0; k < NW; k++) begin
      if (idx == IDX_W'(BASE + k)) begin
        hit  = 1'b1;
        word = padded[(NW-1-k)*CSR_DW +: CSR_DW];
      end
    end
  end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bridge_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CTRL_W = 20,
  parameter int MODE_W = 1,
  parameter int STAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              sel0,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  csr_word_t         wdat,
  input  logic [STAT_W-1:0] stat_i,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [MODE_W-1:0] mode_q,
  output csr_word_t         rdat
);

  localparam int CTRL_BASE = 0;
  localparam int MODE_BASE = CTRL_BASE + csr_words(CTRL_W);
  localparam int STAT_BASE = MODE_BASE + csr_words(MODE_W);

  logic      wr;
  logic      stat_hit;
  csr_word_t stat_word;

  assign wr = req && we && sel0 && hit;

  csr_wo_reg #(.WIDTH(CTRL_W), .BASE(CTRL_BASE), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .wdat(wdat), .q(ctrl_q));

  csr_wo_reg #(.WIDTH(MODE_W), .BASE(MODE_BASE), .IDX_W(IDX_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .wdat(wdat), .q(mode_q));

  csr_ro_reg #(.WIDTH(STAT_W), .BASE(STAT_BASE), .IDX_W(IDX_W)) u_stat (
    .val(stat_i), .idx(idx), .hit(stat_hit), .word(stat_word));

  always_ff @(posedge clk) begin
    if (!rst_n)   rdat <= '0;
    else if (req) rdat <= (!we && hit && stat_hit) ? stat_word : '0;
  end

  // R9
  other_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !hit) |=> ($stable(ctrl_q) && $stable(mode_q)));
  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && stat_hit) |=> ($stable(ctrl_q) && $stable(mode_q)));

endmodule

// File: rtl/wb_csr_bridge.sv
module wb_csr_bridge
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int BANK_ID = 0,
  parameter int CTRL_W  = 20,
  parameter int MODE_W  = 1,
  parameter int STAT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADDR_W-1:0] wb_adr,
  input  logic [31:0]       wb_dat_w,
  input  logic [3:0]        wb_sel,
  output logic [31:0]       wb_dat_r,
  output logic              wb_ack,
  input  logic [STAT_W-1:0] stat_i,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [MODE_W-1:0] mode_q
);

  logic             req, req_we, req_sel0, req_hit;
  logic [IDX_W-1:0] req_idx;
  csr_word_t        req_wdat, rdat;
  logic             unused_hi;

  assign unused_hi = ^{wb_dat_w[31:8], wb_sel[3:1]};

  wb_csr_front #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_ID(BANK_ID)) u_front (
    .clk(clk), .rst_n(rst_n), .cyc(wb_cyc), .stb(wb_stb), .we(wb_we),
    .adr(wb_adr), .wdat(wb_dat_w[7:0]), .sel0(wb_sel[0]),
    .req(req), .req_we(req_we), .req_sel0(req_sel0), .req_hit(req_hit),
    .req_idx(req_idx), .req_wdat(req_wdat), .ack(wb_ack));

  csr_bank #(.IDX_W(IDX_W), .CTRL_W(CTRL_W), .MODE_W(MODE_W), .STAT_W(STAT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .req(req), .we(req_we), .sel0(req_sel0),
    .hit(req_hit), .idx(req_idx), .wdat(req_wdat), .stat_i(stat_i),
    .ctrl_q(ctrl_q), .mode_q(mode_q), .rdat(rdat));

  assign wb_dat_r = wb_ack ? {24'h0, rdat} : 32'h0;

endmodule

// File: tb/wb_csr_bridge_test.sv
module wb_csr_bridge_test;

  localparam int BID = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [31:0] adr = '0, dat_w = '0;
  logic [3:0]  sel = '0;
  logic [31:0] dat_r;
  logic        ack;
  logic [8:0]  stat = '0;
  logic [19:0] ctrl;
  logic [0:0]  mode;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wb_csr_bridge #(.ADDR_W(32), .IDX_W(4), .BANK_ID(BID)) uut (
    .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_adr(adr), .wb_dat_w(dat_w), .wb_sel(sel), .wb_dat_r(dat_r),
    .wb_ack(ack), .stat_i(stat), .ctrl_q(ctrl), .mode_q(mode));

  // behavioural reference
  logic        m_ack = 0;
  logic [31:0] m_rd = 0;
  logic [19:0] m_ctrl = 0;
  logic [3:0]  m_hi = 0;
  logic [7:0]  m_mid = 0;
  logic        m_mode = 0;

  function automatic logic [31:0] mk(input int bank, input int idx, input int low);
    return (32'(bank) << 6) | (32'(idx) << 2) | 32'(low);
  endfunction

  function automatic logic [31:0] mread(input logic [31:0] a);
    if (a[31:6] != 26'(BID)) return 0;
    case (a[5:2])
      4'd4: return {31'd0, stat[8]};
      4'd5: return {24'd0, stat[7:0]};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 0; m_rd <= 0; m_ctrl <= 0; m_hi <= 0; m_mid <= 0; m_mode <= 0;
    end else if (cyc && stb && !m_ack) begin
      m_ack <= 1;
      m_rd  <= we ? 32'd0 : mread(adr);
      if (we && sel[0] && adr[31:6] == 26'(BID)) begin
        case (adr[5:2])
          4'd0: m_hi  <= dat_w[3:0];
          4'd1: m_mid <= dat_w[7:0];
          4'd2: m_ctrl <= {m_hi, m_mid, dat_w[7:0]};
          4'd3: m_mode <= dat_w[0];
          default: ;
        endcase
      end
    end else begin
      m_ack <= 0;
    end
  end

  task automatic cmp(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp(32'(ack), 32'(m_ack), "R1 ack");
      cmp(32'(ctrl), 32'(m_ctrl), "R5 ctrl_q");
      cmp(32'(mode), 32'(m_mode), "R4 mode_q");
      cmp(dat_r, m_ack ? m_rd : 32'd0, "R2 dat_r");
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] rd);
    cyc = 1; stb = 1; we = w; adr = a; dat_w = d; sel = s;
    @(negedge clk);
    while (!ack) @(negedge clk);
    rd = dat_r;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R11 reset state
    cmp(32'(ack), 0, "R11 ack");
    cmp(32'(ctrl), 0, "R11 ctrl_q");
    cmp(32'(mode), 0, "R11 mode_q");
    rst_n = 1;
    @(negedge clk);

    // R5 R4: staged wide write, upper nibble ignored
    xfer(1, mk(BID, 0, 0), 32'hFFFF_FFFA, 4'hF, r);
    cmp(32'(ctrl), 0, "R5 after word0");
    cmp(r, 0, "R2 write ack data");
    xfer(1, mk(BID, 1, 0), 32'h0000_00BC, 4'h1, r);
    cmp(32'(ctrl), 0, "R5 after word1");
    xfer(1, mk(BID, 2, 0), 32'h0000_00DE, 4'h1, r);
    cmp(32'(ctrl), 32'hABCDE, "R5 R4 commit");

    // R6 low lane not selected
    xfer(1, mk(BID, 2, 0), 32'h11, 4'b1110, r);
    cmp(32'(ctrl), 32'hABCDE, "R6 sel0 low");

    // R10 low address bits ignored
    xfer(1, mk(BID, 2, 3), 32'h33, 4'h1, r);
    cmp(32'(ctrl), 32'hABC33, "R10 low bits");

    // R4 mode keeps only bit 0
    xfer(1, mk(BID, 3, 0), 32'hFE, 4'h1, r);
    cmp(32'(mode), 0, "R4 mode bit0 zero");
    xfer(1, mk(BID, 3, 0), 32'hFF, 4'h1, r);
    cmp(32'(mode), 1, "R4 mode set");

    // R3 R2 status layout
    stat = 9'h1A5;
    xfer(0, mk(BID, 4, 0), 0, 4'hF, r);
    cmp(r, 32'h1, "R3 stat msw");
    xfer(0, mk(BID, 5, 2), 0, 4'hF, r);
    cmp(r, 32'hA5, "R3 R2 stat lsw");
    stat = 9'h05A;
    xfer(0, mk(BID, 4, 0), 0, 4'hF, r);
    cmp(r, 32'h0, "R3 stat msw zero");

    // R8 write-only and unmapped read as zero
    xfer(0, mk(BID, 2, 0), 0, 4'hF, r);
    cmp(r, 0, "R8 wo read");
    xfer(0, mk(BID, 9, 0), 0, 4'hF, r);
    cmp(r, 0, "R8 unmapped read");

    // R9 other bank
    xfer(0, mk(BID + 1, 5, 0), 0, 4'hF, r);
    cmp(r, 0, "R9 other bank read");
    xfer(1, mk(BID + 1, 3, 0), 32'h0, 4'h1, r);
    cmp(32'(mode), 1, "R9 other bank write");

    // R7 read-only and unmapped writes discarded
    xfer(1, mk(BID, 5, 0), 32'h77, 4'h1, r);
    xfer(1, mk(BID, 12, 0), 32'h77, 4'h1, r);
    cmp(32'(ctrl), 32'hABC33, "R7 ctrl kept");
    cmp(32'(mode), 1, "R7 mode kept");
    xfer(0, mk(BID, 5, 0), 0, 4'hF, r);
    cmp(r, 32'h5A, "R7 stat unchanged");

    // R1 back-to-back: strobe held across two requests
    cyc = 1; stb = 1; we = 0; adr = mk(BID, 5, 0); sel = 4'hF;
    @(negedge clk);
    cmp(32'(ack), 1, "R1 first ack");
    @(negedge clk);
    cmp(32'(ack), 0, "R1 no double ack");
    @(negedge clk);
    cmp(32'(ack), 1, "R1 second ack");
    cyc = 0; stb = 0;
    @(negedge clk);
    cmp(32'(ack), 0, "R1 idle");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule